// File: doc/BRIEF.md
# LWE Encryption Multiply-Accumulate Engine

This engine produces the ciphertext words of a standard-lattice LWE encryption using one multiply-accumulate datapath. An encryption makes three passes in a fixed order: first public matrix A0, then A1, then P. Each pass produces one output word per matrix column. The word is the dot product of the error vector e1 with that column, plus one fresh Gaussian noise sample. On the P pass the encoded message bit is added as well. All arithmetic is modulo 2^W (4096 by default), so every sum keeps only its low W bits. The matrices sit in an external synchronous memory that the engine addresses by matrix select, row and column.

Gaussian samples arrive on a valid/ready stream. After reset the engine first takes N samples and stores them as the initial e1 vector. From then on, every column takes two samples. The first becomes that column's noise term. The second is written into the standby half of a two-bank e1 store. At the end of each encryption the banks exchange roles, so the next encryption runs on a fresh error vector without a separate refill phase. A start pulse latches the message bits and begins an encryption. A done pulse marks its end.

Top module: `lwe_mac_engine`

## Requirements
- R1: After reset the engine is busy with smp_ready high. It accepts exactly N samples into the active e1 bank, with the k-th sample becoming e1[k], and then drops busy. No ciphertext word appears before a start.
- R2: For passes A0 and A1, each word equals (sum over i of e1[i]·M[i][j] + noise) mod 2^W. The noise is a W-bit two's-complement sample, so negative noise wraps modulo 2^W.
- R3: On the P pass, the word for column j also adds msg_bits[j]·2^(W-1), taken modulo 2^W.
- R4: Words leave in the order pass 0 columns 0..L-1, then pass 1, then pass 2. ct_pass encodes 0 = A0, 1 = A1, 2 = P and never holds 3 with ct_valid. ct_col gives the column.
- R5: Within each column, the first accepted sample is that column's noise. The second accepted sample, taken only while the standby bank is not yet full, goes into the standby bank at the next ascending index. After the columns finish, any samples the standby bank still lacks are taken before done. An encryption therefore consumes 3·L + N samples when 3·L ≥ N.
- R6: At the end of each encryption the banks swap roles. The next encryption uses the e1 vector collected during the previous one.
- R7: A column's word is not emitted until both of its samples (or the noise alone, once the standby bank is full) have been accepted. While the sample stream is empty, no word appears. Two words are never on consecutive cycles.
- R8: done is a single-cycle pulse that comes after the last P-pass word. busy is low while done is high. A start pulse during an encryption is ignored, and the message used is the one latched at the accepted start.
- R9: Matrix reads have one cycle of latency: the data for the address presented with mat_rd_en arrives on mat_rd_data in the next cycle. Reads occur only while busy.
- R10: While idle, smp_ready stays low and no sample is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an encryption when idle |
| msg_bits | input | L | Message, one bit per column, latched at start |
| smp_valid | input | 1 | Gaussian sample present |
| smp_data | input | W | Gaussian sample, two's complement |
| smp_ready | output | 1 | Engine takes the sample this cycle |
| mat_rd_en | output | 1 | Matrix read request |
| mat_sel | output | 2 | Matrix select: 0 A0, 1 A1, 2 P |
| mat_row | output | log2 N | Matrix row index |
| mat_col | output | log2 L | Matrix column index |
| mat_rd_data | input | W | Matrix entry, one cycle after the request |
| ct_valid | output | 1 | Ciphertext word strobe |
| ct_data | output | W | Ciphertext word |
| ct_pass | output | 2 | Pass of the word |
| ct_col | output | log2 L | Column of the word |
| done | output | 1 | End-of-encryption pulse |
| busy | output | 1 | Initialising or encrypting |

## Verification
The bench uses a 4-row, 3-column configuration and checks every word of several back-to-back encryptions against sums it computes itself. The sample stream mixes small values with large positive and negative ones, so that wrap-around in the accumulator and in the noise term both show up. All-zero, all-one and mixed message patterns separate the P-pass message addition from the noise. Runs with a continuous sample stream, a stream that has a gap every third cycle, a stream held off after start, and a stray start pulse separate the per-column sample ordering, stall behaviour and message latching. The later encryptions can only match if the bank swap hands over the vector that was collected.

// File: rtl/lwe_mac_pkg.sv
package lwe_mac_pkg;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_RUN,
        ST_DRAIN,
        ST_FINISH
    } eng_state_t;

    typedef enum logic [1:0] {
        MAT_A0 = 2'd0,
        MAT_A1 = 2'd1,
        MAT_P  = 2'd2
    } mat_sel_t;

    // Per-column sample bookkeeping: noise term and whether the refill slot is served
    typedef struct packed {
        logic [11:0] noise;
        logic        noise_ok;
        logic        refill_ok;
    } col_slot_t;

    function automatic logic [1:0] next_pass(input logic [1:0] p);
        return p + 2'd1;
    endfunction

endpackage

// File: rtl/lwe_e1_store.sv
module lwe_e1_store #(
    parameter int N = 256,
    parameter int W = 12,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          swap,
    input  logic          wr_en,
    input  logic          wr_active,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic         act;
    logic         tgt;
    logic [W-1:0] rd_bank [2];

    assign tgt = wr_active ? act : ~act;

    always_ff @(posedge clk) begin
        if (rst) act <= 1'b0;
        else if (swap) act <= ~act;
    end

    generate
        for (genvar b = 0; b < 2; b++) begin : g_bank
            logic [W-1:0] mem [N];
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (wr_en && (tgt == 1'(b))) mem[wr_idx] <= wr_data;
                q <= mem[rd_idx];
            end
            assign rd_bank[b] = q;
        end
    endgenerate

    assign rd_data = rd_bank[act];
endmodule

// File: rtl/lwe_mac_acc.sv
module lwe_mac_acc #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_first,
    input  logic [W-1:0] op_e,
    input  logic [W-1:0] op_m,
    output logic [W-1:0] acc
);
    logic [W-1:0] prod;

    // Low W bits of the product are exact modulo 2^W for signed or unsigned operands
    assign prod = op_e * op_m;

    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else if (in_valid) acc <= in_first ? prod : acc + prod;
    end
endmodule

// File: rtl/lwe_mac_engine.sv
module lwe_mac_engine
    import lwe_mac_pkg::*;
#(
    parameter int N = 256,
    parameter int L = 128,
    parameter int W = 12,
    localparam int ROW_W  = (N > 1) ? $clog2(N) : 1,
    localparam int COL_W  = (L > 1) ? $clog2(L) : 1,
    localparam int FILL_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [L-1:0]     msg_bits,
    input  logic             smp_valid,
    input  logic [W-1:0]     smp_data,
    output logic             smp_ready,
    output logic             mat_rd_en,
    output logic [1:0]       mat_sel,
    output logic [ROW_W-1:0] mat_row,
    output logic [COL_W-1:0] mat_col,
    input  logic [W-1:0]     mat_rd_data,
    output logic             ct_valid,
    output logic [W-1:0]     ct_data,
    output logic [1:0]       ct_pass,
    output logic [COL_W-1:0] ct_col,
    output logic             done,
    output logic             busy
);
    eng_state_t        state;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    mat_sel_t          pass_q;
    logic [FILL_W-1:0] fill_q;
    logic [L-1:0]      msg_q;
    col_slot_t         slot_q;
    logic              iss_v, iss_first;
    logic [W-1:0]      e1_rd, acc;
    logic              fill_open, col_run, want_noise, want_fill;
    logic              to_noise, to_fill, emit, last_col;
    logic [W-1:0]      msg_add;

    assign fill_open  = (fill_q != FILL_W'(N));
    assign col_run    = (state == ST_RUN) || (state == ST_DRAIN);
    assign want_noise = col_run && !slot_q.noise_ok;
    assign want_fill  = (state == ST_INIT || state == ST_FINISH) ? fill_open
                      : (col_run && slot_q.noise_ok && !slot_q.refill_ok && fill_open);
    assign smp_ready  = want_noise || want_fill;
    assign to_noise   = smp_valid && want_noise;
    assign to_fill    = smp_valid && want_fill;

    assign emit     = (state == ST_DRAIN) && !iss_v && slot_q.noise_ok
                      && (slot_q.refill_ok || !fill_open);
    assign last_col = (pass_q == MAT_P) && (col_q == COL_W'(L - 1));
    assign msg_add  = ((pass_q == MAT_P) && msg_q[col_q]) ? {1'b1, {(W-1){1'b0}}} : '0;

    assign mat_rd_en = (state == ST_RUN);
    assign mat_sel   = pass_q;
    assign mat_row   = row_q;
    assign mat_col   = col_q;
    assign busy      = (state != ST_IDLE);

    lwe_e1_store #(.N(N), .W(W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .swap      ((state == ST_FINISH) && !fill_open),
        .wr_en     (to_fill),
        .wr_active (state == ST_INIT),
        .wr_idx    (fill_q[ROW_W-1:0]),
        .wr_data   (smp_data),
        .rd_idx    (row_q),
        .rd_data   (e1_rd)
    );

    lwe_mac_acc #(.W(W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .in_valid (iss_v),
        .in_first (iss_first),
        .op_e     (e1_rd),
        .op_m     (mat_rd_data),
        .acc      (acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_INIT;
            row_q     <= '0;
            col_q     <= '0;
            pass_q    <= MAT_A0;
            fill_q    <= '0;
            msg_q     <= '0;
            slot_q    <= '0;
            iss_v     <= 1'b0;
            iss_first <= 1'b0;
            ct_valid  <= 1'b0;
            ct_data   <= '0;
            ct_pass   <= '0;
            ct_col    <= '0;
            done      <= 1'b0;
        end else begin
            iss_v     <= (state == ST_RUN);
            iss_first <= (row_q == '0);
            ct_valid  <= 1'b0;
            done      <= 1'b0;
            if (to_noise) begin
                slot_q.noise    <= smp_data;
                slot_q.noise_ok <= 1'b1;
            end
            if (to_fill) begin
                fill_q <= fill_q + 1'b1;
                if (col_run) slot_q.refill_ok <= 1'b1;
            end
            case (state)
                ST_INIT: if (!fill_open) state <= ST_IDLE;
                ST_IDLE: if (start) begin
                    msg_q  <= msg_bits;
                    fill_q <= '0;
                    row_q  <= '0;
                    col_q  <= '0;
                    pass_q <= MAT_A0;
                    state  <= ST_RUN;
                end
                ST_RUN: begin
                    if (row_q == ROW_W'(N - 1)) begin
                        row_q <= '0;
                        state <= ST_DRAIN;
                    end else begin
                        row_q <= row_q + 1'b1;
                    end
                end
                ST_DRAIN: if (emit) begin
                    ct_valid         <= 1'b1;
                    ct_data          <= acc + slot_q.noise + msg_add;
                    ct_pass          <= pass_q;
                    ct_col           <= col_q;
                    slot_q.noise_ok  <= 1'b0;
                    slot_q.refill_ok <= 1'b0;
                    if (last_col) begin
                        state <= ST_FINISH;
                    end else begin
                        state <= ST_RUN;
                        if (col_q == COL_W'(L - 1)) begin
                            col_q  <= '0;
                            pass_q <= mat_sel_t'(next_pass(pass_q));
                        end else begin
                            col_q <= col_q + 1'b1;
                        end
                    end
                end
                ST_FINISH: if (!fill_open) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lwe_mac_engine_chk.sv
module lwe_mac_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       smp_ready,
    input logic       ct_valid,
    input logic [1:0] ct_pass,
    input logic       done,
    input logic       mat_rd_en
);
    p_idle_no_take_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !smp_ready);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_apart_r8: assert property (@(posedge clk) disable iff (rst)
        !(done && ct_valid));

    p_ct_spacing_r7: assert property (@(posedge clk) disable iff (rst)
        ct_valid |=> !ct_valid);

    p_pass_code_r4: assert property (@(posedge clk) disable iff (rst)
        ct_valid |-> (ct_pass != 2'd3));

    p_read_busy_r9: assert property (@(posedge clk) disable iff (rst)
        mat_rd_en |-> busy);
endmodule

bind lwe_mac_engine lwe_mac_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .smp_ready (smp_ready),
    .ct_valid  (ct_valid),
    .ct_pass   (ct_pass),
    .done      (done),
    .mat_rd_en (mat_rd_en)
);

// File: tb/test_lwe_mac_engine.sv
module test_lwe_mac_engine;
    localparam int N = 4;
    localparam int L = 3;
    localparam int W = 12;
    localparam int NC = 3 * L;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [L-1:0] msg_bits = '0;
    logic         smp_valid;
    logic [W-1:0] smp_data;
    logic         smp_ready;
    logic         mat_rd_en;
    logic [1:0]   mat_sel;
    logic [1:0]   mat_row;
    logic [1:0]   mat_col;
    logic [W-1:0] mat_rd_data = '0;
    logic         ct_valid;
    logic [W-1:0] ct_data;
    logic [1:0]   ct_pass;
    logic [1:0]   ct_col;
    logic         done;
    logic         busy;

    always #2 clk = ~clk;

    lwe_mac_engine #(.N(N), .L(L), .W(W)) i_lwe_mac_engine (
        .clk(clk), .rst(rst), .start(start), .msg_bits(msg_bits),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
        .mat_rd_en(mat_rd_en), .mat_sel(mat_sel), .mat_row(mat_row), .mat_col(mat_col),
        .mat_rd_data(mat_rd_data), .ct_valid(ct_valid), .ct_data(ct_data),
        .ct_pass(ct_pass), .ct_col(ct_col), .done(done), .busy(busy)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    function automatic logic [11:0] mat_val(int p, int r, int c);
        return 12'((p * 1237 + r * 389 + c * 71 + 3) % 4096);
    endfunction

    function automatic logic [11:0] smp_val(int k);
        int v;
        v = ((k * 53 + 11) % 31) - 15;
        if (k % 7 == 3) v = -2000;
        if (k % 11 == 5) v = 1900;
        return 12'(v);
    endfunction

    // synchronous matrix memory, one cycle latency
    always @(posedge clk)
        if (mat_rd_en) mat_rd_data <= mat_val(int'(mat_sel), int'(mat_row), int'(mat_col));

    // sample source
    int k_drv = 0;
    int cyc = 0;
    bit src_en = 0;
    bit gap_mode = 0;
    assign smp_valid = src_en && !(gap_mode && (cyc % 3 == 1));
    assign smp_data  = smp_val(k_drv);
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && smp_valid && smp_ready) k_drv <= k_drv + 1;
    end

    // output monitor
    int gi = 0;
    int done_n = 0;
    int got_d [NC];
    int got_p [NC];
    int got_c [NC];
    always @(negedge clk) begin
        if (ct_valid) begin
            if (gi < NC) begin
                got_d[gi] = int'(ct_data);
                got_p[gi] = int'(ct_pass);
                got_c[gi] = int'(ct_col);
            end
            gi = gi + 1;
        end
        if (done) done_n = done_n + 1;
    end

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference model
    logic [11:0] e1_m [N];
    logic [11:0] fill_m [N];
    int exp_d [NC];
    int mk = 0;
    int enc_no = 0;

    task automatic build_exp(logic [L-1:0] msg);
        int fm = 0;
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < L; c++) begin
                int s = 0;
                int nz = int'(smp_val(mk));
                mk++;
                if (fm < N) begin
                    fill_m[fm] = smp_val(mk);
                    fm++;
                    mk++;
                end
                for (int i = 0; i < N; i++)
                    s = (s + int'(e1_m[i]) * int'(mat_val(p, i, c))) % 4096;
                s = s + nz;
                if (p == 2 && msg[c]) s = s + 2048;
                exp_d[p * L + c] = s % 4096;
            end
        end
        while (fm < N) begin
            fill_m[fm] = smp_val(mk);
            fm++;
            mk++;
        end
    endtask

    task automatic run_enc(logic [L-1:0] msg, bit gaps, bit stall, bit poke);
        int d0;
        build_exp(msg);
        gi = 0;
        d0 = done_n;
        gap_mode = gaps;
        src_en = !stall;
        @(negedge clk);
        start = 1'b1;
        msg_bits = msg;
        @(negedge clk);
        start = 1'b0;
        msg_bits = ~msg;
        if (stall) begin
            repeat (3 * N + 10) @(negedge clk);
            chk(gi == 0, "R7 no word while stream empty", gi, 0);
            chk(busy == 1'b1, "R7 still busy while stalled", int'(busy), 1);
            src_en = 1;
        end
        if (poke) begin
            repeat (N + 3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_n == d0) @(negedge clk);
        chk(busy == 1'b0, "R8 idle with done", int'(busy), 0);
        chk(gi == NC, "R8 word count before done", gi, NC);
        for (int x = 0; x < NC; x++) begin
            string rq;
            if (enc_no == 0) rq = (x / L == 2) ? "R3" : "R2";
            else rq = (x / L == 2) ? "R3/R6" : "R2/R6";
            chk(got_d[x] == exp_d[x], rq, got_d[x], exp_d[x]);
            chk(got_p[x] == x / L && got_c[x] == x % L, "R4 order",
                got_p[x] * 16 + got_c[x], (x / L) * 16 + x % L);
        end
        repeat (4) @(negedge clk);
        chk(done_n == d0 + 1, "R8 single done", done_n - d0, 1);
        chk(gi == NC, "R8 stray start ignored", gi, NC);
        chk(k_drv == mk, "R5 samples consumed", k_drv, mk);
        for (int i = 0; i < N; i++) e1_m[i] = fill_m[i];
        enc_no++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b1, "R1 busy after reset", int'(busy), 1);
        chk(smp_ready == 1'b1, "R1 ready during init", int'(smp_ready), 1);
        chk(ct_valid == 1'b0 && done == 1'b0, "R1 quiet outputs", int'(ct_valid) + int'(done), 0);
        src_en = 1;
        while (busy) @(negedge clk);
        chk(k_drv == N, "R1 init sample count", k_drv, N);
        for (int i = 0; i < N; i++) e1_m[i] = smp_val(i);
        mk = N;
        // R10 idle window with samples offered
        repeat (12) @(negedge clk);
        chk(k_drv == N, "R10 no take while idle", k_drv, N);
        chk(smp_ready == 1'b0, "R10 ready low while idle", int'(smp_ready), 0);
        chk(gi == 0, "R1 no word before start", gi, 0);

        run_enc(3'b000, 0, 0, 0);
        run_enc(3'b111, 1, 0, 0);
        run_enc(3'b101, 0, 1, 0);
        run_enc(3'b010, 1, 0, 1);
        run_enc(3'b110, 0, 0, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule